// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block checks one memory access against a 64-bit memory-segment descriptor. It takes the descriptor, a 32-bit offset, the access kind and the current privilege level. The base and limit are spread across several fields of the descriptor, so the block first gathers them. It scales the limit by the granularity flag. It then checks presence, descriptor class, privilege, access rights and the limit, with the limit test reversed for expand-down data segments. A request that passes every check returns the linear address, which is the base plus the offset. A request that fails returns a single fault flag and a cause code.

Each request is presented for one cycle with `req_valid`. The response is registered and appears on the next clock edge with `rsp_valid`. A new request can be issued every cycle. Only memory-segment descriptors are handled.

Descriptor layout used here:
- limit bits [15:0] at descriptor bits 15:0, limit bits [19:16] at 51:48
- base bits [23:0] at 39:16, base bits [31:24] at 63:56
- type at 43:40, class bit S at 44 (1 = memory), DPL at 46:45, present P at 47, granularity G at 55

Top module: `seg_access_check`

## Requirements
- R1: When no check fails, `lin_addr` equals base + offset modulo 2^32. The base is assembled from descriptor bits 63:56 (upper byte) and 39:16 (lower 24 bits).
- R2: The 20-bit limit is {desc[51:48], desc[15:0]}. With G (bit 55) clear, the effective limit is that value in bytes. With G set, it is the value shifted left by 12 with bits 11:0 all ones.
- R3: For a segment that is not expand-down, an offset greater than the effective limit faults with cause 5. An offset equal to the limit passes.
- R4: A data segment with type[3]=0 and type[2]=1 is expand-down. It accepts only offsets strictly greater than the effective limit; an offset at or below the limit faults with cause 5.
- R5: Access kind is coded 0 read, 1 write, 2 execute, 3 reserved. Write passes only for types 2 and 6. Read fails for types 8 and C. Execute passes only for types 8, A, C and D. Kind 3 always fails. Each refusal has cause 4.
- R6: Types with type[3:2]=11 are conforming and skip the privilege check. For any other type, a CPL numerically greater than DPL faults with cause 3.
- R7: Causes are checked in this priority order: not present (P=0) gives cause 1, system class (S=0) gives cause 2, then privilege (3), permission (4) and limit (5). On success the cause is 0.
- R8: `fault` is 1 exactly when the cause is non-zero. While `fault` is 1, `lin_addr` is 0.
- R9: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. While `rsp_valid` is low, `fault`, `cause` and `lin_addr` are 0. Reset (`rst_n` low) clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| desc | input | 64 | Segment descriptor |
| offset | input | 32 | Offset within the segment |
| kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| fault | output | 1 | Access refused |
| cause | output | 3 | Fault cause: 0 none, 1 absent, 2 system, 3 privilege, 4 rights, 5 limit |
| lin_addr | output | 32 | Linear address, 0 on fault |

## Verification
The hardest case to reach is the exact limit boundary under page granularity. Random offsets almost never land on the scaled limit or one past it, and never do so in an expand-down segment. Directed cases therefore place the offset at the effective limit and at the limit plus one, for both granularities and both limit directions. The random stimulus also sets P and S most of the time, so that requests get past the earlier checks to the privilege, rights and limit checks. Other directed cases break several conditions at once, to check the cause priority.

// File: rtl/seg_access_check.sv
module seg_access_check (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] desc,
  input  logic [31:0] offset,
  input  logic [1:0]  kind,
  input  logic [1:0]  cpl,
  output logic        rsp_valid,
  output logic        fault,
  output logic [2:0]  cause,
  output logic [31:0] lin_addr
);
  logic [31:0] base, eff_lim;
  logic [19:0] lim20;
  logic [3:0]  typ;
  logic [1:0]  dpl;
  logic        pres, memcls, gran;
  logic        expdn, conf, priv_bad, rights_bad, lim_bad;
  logic [2:0]  cause_d;

  assign base    = {desc[63:56], desc[39:16]};
  assign lim20   = {desc[51:48], desc[15:0]};
  assign typ     = desc[43:40];
  assign memcls  = desc[44];
  assign dpl     = desc[46:45];
  assign pres    = desc[47];
  assign gran    = desc[55];
  assign eff_lim = gran ? {lim20, 12'hFFF} : {12'h000, lim20};

  assign expdn    = !typ[3] && typ[2];
  assign conf     = typ[3] && typ[2];
  assign priv_bad = !conf && (cpl > dpl);
  assign lim_bad  = expdn ? (offset <= eff_lim) : (offset > eff_lim);

  always_comb begin
    case (kind)
      2'd0:    rights_bad = (typ == 4'h8) || (typ == 4'hC);
      2'd1:    rights_bad = !((typ == 4'h2) || (typ == 4'h6));
      2'd2:    rights_bad = !((typ == 4'h8) || (typ == 4'hA) ||
                              (typ == 4'hC) || (typ == 4'hD));
      default: rights_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!pres)           cause_d = 3'd1;
    else if (!memcls)    cause_d = 3'd2;
    else if (priv_bad)   cause_d = 3'd3;
    else if (rights_bad) cause_d = 3'd4;
    else if (lim_bad)    cause_d = 3'd5;
    else                 cause_d = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid <= 1'b0;
      fault     <= 1'b0;
      cause     <= 3'd0;
      lin_addr  <= 32'd0;
    end else begin
      rsp_valid <= 1'b1;
      fault     <= (cause_d != 3'd0);
      cause     <= cause_d;
      lin_addr  <= (cause_d == 3'd0) ? base + offset : 32'd0;
    end
  end
endmodule

module seg_access_check_props (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] desc,
  input logic [31:0] offset,
  input logic        rsp_valid,
  input logic        fault,
  input logic [2:0]  cause,
  input logic [31:0] lin_addr
);
  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!fault && cause == 3'd0 && lin_addr == 32'd0));
  p_fault_zero_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (lin_addr == 32'd0 && cause != 3'd0));
  p_absent_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !desc[47]) |=> (fault && cause == 3'd1));
  p_ok_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault) |->
      lin_addr == $past({desc[63:56], desc[39:16]} + offset));
  p_cause_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cause <= 3'd5);
endmodule

bind seg_access_check seg_access_check_props u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .desc(desc),
  .offset(offset), .rsp_valid(rsp_valid), .fault(fault), .cause(cause),
  .lin_addr(lin_addr)
);

// File: tb/seg_access_check_test.sv
module seg_access_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] desc = '0;
  logic [31:0] offset = '0;
  logic [1:0]  kind = '0;
  logic [1:0]  cpl = '0;
  logic        rsp_valid, fault;
  logic [2:0]  cause;
  logic [31:0] lin_addr;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  seg_access_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .desc(desc),
    .offset(offset), .kind(kind), .cpl(cpl), .rsp_valid(rsp_valid),
    .fault(fault), .cause(cause), .lin_addr(lin_addr)
  );

  function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l, logic g,
      logic p, logic s, logic [1:0] d, logic [3:0] t);
    logic [63:0] x = '0;
    x[15:0] = l[15:0]; x[51:48] = l[19:16];
    x[39:16] = b[23:0]; x[63:56] = b[31:24];
    x[43:40] = t; x[44] = s; x[46:45] = d; x[47] = p; x[55] = g;
    return x;
  endfunction

  function automatic logic [2:0] exp_cause(logic [63:0] dd, logic [31:0] o,
      logic [1:0] k, logic [1:0] c);
    logic [3:0] t = dd[43:40];
    logic [31:0] el;
    logic ok;
    el = {12'h0, dd[51:48], dd[15:0]};
    if (dd[55]) el = (el << 12) | 32'hFFF;
    if (!dd[47]) return 3'd1;
    if (!dd[44]) return 3'd2;
    if (t < 4'hC && c > dd[46:45]) return 3'd3;
    case (k)
      2'd0: ok = !(t == 4'h8 || t == 4'hC);
      2'd1: ok = (t == 4'h2 || t == 4'h6);
      2'd2: ok = (t == 4'h8 || t == 4'hA || t == 4'hC || t == 4'hD);
      default: ok = 1'b0;
    endcase
    if (!ok) return 3'd4;
    if (t[3] == 1'b0 && t[2]) begin
      if (o <= el) return 3'd5;
    end else if (o > el) return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(string req, logic [2:0] ec, logic [31:0] ea, logic ev);
    n_chk++;
    if (rsp_valid !== ev || cause !== ec || fault !== (ec != 0) || lin_addr !== ea) begin
      n_bad++;
      $display("FAIL %s: got v=%0b f=%0b c=%0d a=%h, expected v=%0b c=%0d a=%h",
               req, rsp_valid, fault, cause, lin_addr, ev, ec, ea);
    end
  endtask

  task automatic run(string req, logic [63:0] dd, logic [31:0] o,
      logic [1:0] k, logic [1:0] c);
    logic [2:0] ec;
    logic [31:0] ea;
    @(negedge clk);
    desc = dd; offset = o; kind = k; cpl = c; req_valid = 1'b1;
    ec = exp_cause(dd, o, k, c);
    ea = (ec == 0) ? {dd[63:56], dd[39:16]} + o : 32'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, ec, ea, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] dd;
    logic [3:0] tt;
    logic [3:0] codes [8] = '{4'h0, 4'h2, 4'h4, 4'h6, 4'h8, 4'hA, 4'hC, 4'hD};
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R9 reset", 3'd0, 32'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", 3'd0, 32'd0, 1'b0);

    dd = mk(32'hAB12_3400, 20'h00FFF, 0, 1, 1, 2'd0, 4'h2);
    run("R1 base+offset", dd, 32'h10, 2'd1, 2'd0);
    run("R3 at limit", dd, 32'hFFF, 2'd0, 2'd0);
    run("R3 past limit", dd, 32'h1000, 2'd0, 2'd0);
    dd = mk(32'hFFFF_F000, 20'h00002, 1, 1, 1, 2'd3, 4'h2);
    run("R2 page limit edge", dd, 32'h2FFF, 2'd0, 2'd3);
    run("R2 page limit over", dd, 32'h3000, 2'd0, 2'd3);
    dd = mk(32'h0, 20'h0FFFF, 0, 1, 1, 2'd3, 4'h6);
    run("R4 expand-down at limit", dd, 32'hFFFF, 2'd1, 2'd0);
    run("R4 expand-down above", dd, 32'h10000, 2'd1, 2'd0);
    run("R4 expand-down top", dd, 32'hFFFF_FFFF, 2'd0, 2'd0);
    dd = mk(32'h1000, 20'hFFFFF, 1, 1, 1, 2'd3, 4'h8);
    run("R5 read exec-only", dd, 32'h0, 2'd0, 2'd0);
    run("R5 write code", dd, 32'h0, 2'd1, 2'd0);
    run("R5 reserved kind", dd, 32'h0, 2'd3, 2'd0);
    dd = mk(32'h1000, 20'hFFFFF, 1, 1, 1, 2'd0, 4'hD);
    run("R6 conforming skips priv", dd, 32'h40, 2'd0, 2'd3);
    dd = mk(32'h1000, 20'hFFFFF, 1, 1, 1, 2'd0, 4'hA);
    run("R6 priv fault", dd, 32'h40, 2'd2, 2'd3);
    dd = mk(32'h1000, 20'h0, 0, 0, 0, 2'd0, 4'h8);
    run("R7 absent beats all", dd, 32'h40, 2'd1, 2'd3);
    dd = mk(32'h1000, 20'h0, 0, 1, 0, 2'd0, 4'h8);
    run("R7 system beats priv", dd, 32'h40, 2'd1, 2'd3);
    dd = mk(32'h1000, 20'h0, 0, 1, 1, 2'd0, 4'h8);
    run("R7 priv beats rights", dd, 32'h40, 2'd1, 2'd3);
    run("R8 fault address zero", dd, 32'h40, 2'd1, 2'd0);

    for (int i = 0; i < 3000; i++) begin
      tt = codes[$urandom_range(0, 7)];
      dd = {$urandom(), $urandom()};
      dd[43:40] = tt;
      dd[47] = ($urandom_range(0, 15) != 0);
      dd[44] = ($urandom_range(0, 15) != 0);
      if (i % 3 == 0) begin
        logic [31:0] el;
        el = {12'h0, dd[51:48], dd[15:0]};
        if (dd[55]) el = (el << 12) | 32'hFFF;
        run("R1-rand R3 R4 edge", dd, el + $urandom_range(0, 1), 2'($urandom_range(0, 3)),
            2'($urandom_range(0, 3)));
      end else
        run("R5 R6 R7 rand", dd, $urandom(), 2'($urandom_range(0, 3)),
            2'($urandom_range(0, 3)));
    end
    @(negedge clk);
    check("R9 after burst", 3'd0, 32'd0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule